// File: doc/BRIEF.md
# Shared-Adder Arithmetic and Logic Unit with Condition Flags

This block is a purely combinational arithmetic and logic unit for a datapath of parameterised width (32 bits by default). It receives two operands and a 3-bit operation code and returns one result word together with four condition flags: carry, signed overflow, zero, and a sign flag that gives the signed order of the operands. There are no registers, so every output follows the inputs in the same cycle.

Addition and subtraction use a single ripple adder. In subtract mode every bit of the second operand is inverted and the carry into bit 0 is forced high, which adds the two's complement of that operand. The four bitwise operations work on every bit position at once. The sign flag is the top result bit corrected by the overflow flag. After a subtraction it therefore tells whether the first operand is below the second as signed numbers, even when the difference itself overflows.

Top module: `alu_core`

## Requirements
- R1: Operation code 3'b000 gives result = (A + B) mod 2^W.
- R2: Operation code 3'b001 gives result = (A + ~B + 1) mod 2^W, which is (A - B) mod 2^W.
- R3: Codes 3'b010, 3'b011, 3'b100 and 3'b101 give the bitwise AND, OR, XOR and NOR of A and B.
- R4: Codes 3'b110 and 3'b111 give an all-zero result.
- R5: For add, carry_o is the carry out of bit W-1. For subtract, carry_o is the carry out of A + ~B + 1, which is 1 exactly when A >= B as unsigned numbers.
- R6: For add, ovf_o is 1 when A and B are both non-negative and the result is negative, or when both are negative and the result is non-negative.
- R7: For subtract, ovf_o is 1 when A is non-negative, B is negative and the result is negative, or when A is negative, B is non-negative and the result is non-negative.
- R8: For the bitwise operations and the unused codes, carry_o and ovf_o are 0.
- R9: zero_o is 1 exactly when every result bit is 0.
- R10: neg_o is result bit W-1 XOR ovf_o. For add and subtract it equals the sign of the exact signed result, so for subtract it is 1 exactly when A < B as signed numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | W | Operation result |
| carry_o | output | 1 | Carry out of the adder (0 for non-arithmetic codes) |
| ovf_o | output | 1 | Signed overflow (0 for non-arithmetic codes) |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Overflow-corrected sign, signed A < B after subtract |

## Verification
The bench builds two copies of the block side by side, one with W = 32 and one with W = 4. The 4-bit copy makes an exhaustive sweep possible: every operand pair is run under all eight operation codes. That sweep covers every overflow pattern, every wrap of the most negative value and every unused code. The 32-bit copy is driven with the extreme operands (zero, all ones, most negative, most positive, one) in all pairings and with random words. These cases check that the long carry chain and the corrected sign flag behave the same at full width.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_NOR  = 3'b101,
        OP_RSV6 = 3'b110,
        OP_RSV7 = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_x;
    logic [W:0]   chain;

    assign b_x      = b ^ {W{sub}};
    assign chain[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = a[i] ^ b_x[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b_x[i]) | ((a[i] | b_x[i]) & chain[i]);
    end

    assign cout = chain[W];

    always_comb begin
        if (sub) begin
            ovf = (~a[MSB] &  b[MSB] &  sum[MSB]) |
                  ( a[MSB] & ~b[MSB] & ~sum[MSB]);
        end else begin
            ovf = (~a[MSB] & ~b[MSB] &  sum[MSB]) |
                  ( a[MSB] &  b[MSB] & ~sum[MSB]);
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (fn)
                LG_AND:  y[i] =   a[i] & b[i];
                LG_OR:   y[i] =   a[i] | b[i];
                LG_XOR:  y[i] =   a[i] ^ b[i];
                LG_NOR:  y[i] = ~(a[i] | b[i]);
                default: y[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         zero_o,
    output logic         neg_o
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    logic         is_sub;
    logic_fn_e    lfn;
    logic [W-1:0] arith_y;
    logic [W-1:0] logic_y;
    logic         arith_c;
    logic         arith_v;

    assign op     = alu_op_e'(op_sel);
    assign is_sub = (op == OP_SUB);

    always_comb begin
        unique case (op)
            OP_OR:   lfn = LG_OR;
            OP_XOR:  lfn = LG_XOR;
            OP_NOR:  lfn = LG_NOR;
            default: lfn = LG_AND;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a    (opnd_a),
        .b    (opnd_b),
        .sub  (is_sub),
        .sum  (arith_y),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    alu_logic #(.W(W)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (lfn),
        .y  (logic_y)
    );

    always_comb begin
        result  = '0;
        carry_o = 1'b0;
        ovf_o   = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result  = arith_y;
                carry_o = arith_c;
                ovf_o   = arith_v;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOR: result = logic_y;
            default: result = '0;
        endcase
    end

    assign zero_o = ~|result;
    assign neg_o  = result[MSB] ^ ovf_o;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result,
    input logic         carry_o,
    input logic         ovf_o,
    input logic         zero_o,
    input logic         neg_o
);
    always_comb begin
        // R4
        if (op_sel[2:1] == 2'b11)
            rsv_zero_chk: assert (result == '0 && zero_o && !neg_o);
        // R8
        if (op_sel >= 3'd2)
            logic_flags_chk: assert (!carry_o && !ovf_o);
        // R2
        if (op_sel == 3'd1 && opnd_b == '0)
            sub_zero_b_chk: assert (result == opnd_a && carry_o && !ovf_o);
        // R10
        if (op_sel == 3'd1 && opnd_a == opnd_b)
            sub_equal_chk: assert (zero_o && !neg_o && carry_o);
        // R1
        if (op_sel == 3'd0 && opnd_a == '0)
            add_zero_a_chk: assert (result == opnd_b && !ovf_o && !carry_o);
        // R6
        if (op_sel == 3'd0 && opnd_a[W-1] != opnd_b[W-1])
            no_overflow_chk: assert (!ovf_o);
    end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_alu_core_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_sel  (op_sel),
    .result  (result),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .zero_o  (zero_o),
    .neg_o   (neg_o)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;

    typedef struct {
        logic [31:0] res;
        logic        c, v, z, n;
    } flags_t;

    typedef struct {
        logic [31:0] a, b;
        logic [2:0]  op;
        flags_t      e32, e4;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] a32, b32;
    logic [2:0]  op;
    logic [31:0] r32;
    logic        c32, v32, z32, n32;
    logic [3:0]  r4;
    logic        c4, v4, z4, n4;

    int tests = 0;
    int fails = 0;
    item_t q[$];

    alu_core #(.W(32)) u_alu_core (
        .opnd_a(a32), .opnd_b(b32), .op_sel(op), .result(r32),
        .carry_o(c32), .ovf_o(v32), .zero_o(z32), .neg_o(n32)
    );

    alu_core #(.W(4)) u_alu_core_w4 (
        .opnd_a(a32[3:0]), .opnd_b(b32[3:0]), .op_sel(op), .result(r4),
        .carry_o(c4), .ovf_o(v4), .zero_o(z4), .neg_o(n4)
    );

    function automatic flags_t model(int w, logic [31:0] a, logic [31:0] b, logic [2:0] o);
        flags_t f;
        logic [63:0] mask, ua, ub, u;
        longint sa, sb, sv, smax, smin;
        mask = (64'd1 << w) - 64'd1;
        ua = {32'd0, a} & mask;
        ub = {32'd0, b} & mask;
        sa = ua[w-1] ? longint'(ua) - (longint'(1) <<< w) : longint'(ua);
        sb = ub[w-1] ? longint'(ub) - (longint'(1) <<< w) : longint'(ub);
        smax = (longint'(1) <<< (w-1)) - 1;
        smin = -(longint'(1) <<< (w-1));
        f.c = 1'b0; f.v = 1'b0; u = '0; sv = 0;
        case (o)
            3'd0: begin u = ua + ub; sv = sa + sb; end
            3'd1: begin u = ua + ((~ub) & mask) + 64'd1; sv = sa - sb; end
            3'd2: u = ua & ub;
            3'd3: u = ua | ub;
            3'd4: u = ua ^ ub;
            3'd5: u = (~(ua | ub)) & mask;
            default: u = '0;
        endcase
        f.res = 32'(u & mask);
        if (o <= 3'd1) begin
            f.c = u[w];
            f.v = (sv > smax) || (sv < smin);
            f.n = (sv < 0);
        end else begin
            f.n = f.res[w-1];
        end
        f.z = (f.res == 32'd0);
        return f;
    endfunction

    function automatic string res_req(logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd6, 3'd7: return "R4";
            default: return "R3";
        endcase
    endfunction

    function automatic string ovf_req(logic [2:0] o);
        case (o)
            3'd0: return "R6";
            3'd1: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, string what, int w, logic [31:0] got, logic [31:0] exp, item_t it);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s W=%0d op=%0d a=%h b=%h got=%h exp=%h",
                     req, what, w, it.op, it.a, it.b, got, exp);
        end
    endtask

    task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] o);
        item_t it;
        @(posedge clk);
        a32 = a; b32 = b; op = o;
        it.a = a; it.b = b; it.op = o;
        it.e32 = model(32, a, b, o);
        it.e4  = model(4, a, b, o);
        q.push_back(it);
    endtask

    // monitor: pop one expected item per cycle, compare away from posedge
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(res_req(it.op), "result", 32, r32, it.e32.res, it);
            check((it.op <= 3'd1) ? "R5" : "R8", "carry", 32, 32'(c32), 32'(it.e32.c), it);
            check(ovf_req(it.op), "ovf", 32, 32'(v32), 32'(it.e32.v), it);
            check("R9", "zero", 32, 32'(z32), 32'(it.e32.z), it);
            check("R10", "neg", 32, 32'(n32), 32'(it.e32.n), it);
            check(res_req(it.op), "result", 4, 32'(r4), it.e4.res, it);
            check((it.op <= 3'd1) ? "R5" : "R8", "carry", 4, 32'(c4), 32'(it.e4.c), it);
            check(ovf_req(it.op), "ovf", 4, 32'(v4), 32'(it.e4.v), it);
            check("R9", "zero", 4, 32'(z4), 32'(it.e4.z), it);
            check("R10", "neg", 4, 32'(n4), 32'(it.e4.n), it);
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] corner [5];
        corner[0] = 32'h0000_0000;
        corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h8000_0000;
        corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h0000_0001;
        a32 = '0; b32 = '0; op = 3'd0;
        repeat (3) @(posedge clk);
        // reset state: zero inputs give a zero result with only zero_o set (R9)
        @(negedge clk);
        tests++;
        if (!(r32 == 32'd0 && z32 && !c32 && !v32 && !n32)) begin
            fails++;
            $display("FAIL R9 reset-state got=%h/%b%b%b%b exp=0/0010", r32, c32, v32, z32, n32);
        end
        rst_n = 1'b1;
        // exhaustive 4-bit sweep, upper bits random
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    drive({$urandom() & 32'hFFFF_FFF0} | 32'(x),
                          {$urandom() & 32'hFFFF_FFF0} | 32'(y), 3'(o));
        // full-width extremes in every pairing
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    drive(corner[i], corner[j], 3'(o));
        // random full-width words
        for (int k = 0; k < 400; k++)
            drive($urandom(), $urandom(), 3'($urandom_range(0, 7)));
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule